// File: doc/BRIEF.md
# Serial Port Bring-Up Sequencer

This block is a small hardware controller that takes a buffered serial port out of reset in a fixed, safe order, so that the port can serve as an SPI master or an SPI slave. It owns three reset-release controls: one for the sample-rate generator, one for the transmit/receive data paths, and one for the frame-sync logic. Each control is a level that reads 1 when its part is running and 0 when that part is held in reset. The shift engine, the clock generator and the configuration registers sit outside the block. They appear here only as status inputs: a generator clock enable pulse, a DMA-ready flag and a transmit-buffer-loaded flag.

A one-cycle `start_i` pulse in idle captures the role (master or slave) and the servicing mode (CPU or DMA). The sequencer then holds the data paths and frame sync in reset, then holds the generator in reset for a configuration slot, and then releases the generator. It counts WAIT_TICKS generator clock periods, waits for DMA readiness when DMA mode was captured, and releases the data paths. It counts WAIT_TICKS periods again. In master mode it then waits for transmit data and releases frame sync. In master role the port's transmit data line serves as the master-out line and the receive line serves as the master-in line. That wiring is outside this block. Only the frame-sync release depends on the role. `busy_o` and `done_o` report the progress. `abort_i` drops everything back to reset at any time.

Top module: `spi_bringup_seq`

## Requirements
- R1: After `rst_n` is low, `gen_run_o`, `path_run_o`, `fsync_run_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` pulse in idle drives `path_run_o` and `fsync_run_o` to 0 at the next edge and drives `gen_run_o` to 0 at the edge after that. `busy_o` is 1 from the edge after `start_i` onward. `start_i` has no effect while `busy_o` is 1.
- R3: `gen_run_o` rises while `path_run_o` and `fsync_run_o` are both 0. `path_run_o` never rises while `gen_run_o` is 0.
- R4: The first wait counts only edges at which `gen_tick_i` is 1, starting after the edge at which `gen_run_o` rose. In CPU mode `path_run_o` rises at the edge that follows the edge sampling the WAIT_TICKS-th such tick. In DMA mode it rises no earlier than that edge.
- R5: In DMA mode (`dma_mode_i` = 1 at start), `path_run_o` rises only at an edge where `dma_ready_i` is 1.
- R6: The second wait counts WAIT_TICKS ticks after the edge at which `path_run_o` rose. In slave mode `done_o` rises at the edge that samples the WAIT_TICKS-th tick. In master mode `fsync_run_o` rises no earlier than the edge after that.
- R7: `fsync_run_o` rises only in master mode (`master_i` = 1 at start) and only at an edge where `tx_loaded_i` is 1. In slave mode it stays 0.
- R8: Each release step sets exactly one control. During a sequence, no control that has been released falls again.
- R9: `abort_i` = 1 at an edge drives all three controls, `busy_o` and `done_o` to 0 at that edge. A later `start_i` runs a full sequence.
- R10: `done_o` is 1 for exactly one cycle per sequence, with `busy_o` still 1 in that cycle. `busy_o` is 0 in the cycle after.
- R11: Role and servicing mode are captured at `start_i`. Changes on `master_i` and `dma_mode_i` later in the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured in idle only |
| abort_i | input | 1 | Synchronous abort back to idle, all held in reset |
| master_i | input | 1 | 1 = SPI master role, 0 = slave, captured at start |
| dma_mode_i | input | 1 | 1 = buffers serviced by DMA, captured at start |
| dma_ready_i | input | 1 | DMA channels configured and ready |
| tx_loaded_i | input | 1 | Transmit buffer holds data |
| gen_tick_i | input | 1 | One-cycle enable marking a generator clock period |
| gen_run_o | output | 1 | 1 = sample-rate generator out of reset |
| path_run_o | output | 1 | 1 = transmitter and receiver out of reset |
| fsync_run_o | output | 1 | 1 = frame-sync logic out of reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps role, servicing mode and tick spacing of one, two and three cycles. It combines these with DMA-ready and transmit-loaded that arrive either at once or late. In every run it counts generator ticks between releases. A counter that ran on every system clock would release the data paths early when ticks are sparse. A counter that took in the tick at the release edge itself would be off by one period. A sequencer that ignored DMA readiness would release the paths while `dma_ready_i` is low. One that released frame sync in slave mode, or before data was loaded, would show a rise at the wrong edge. After start the bench flips `master_i` and `dma_mode_i` and sends a stray `start_i`, so a design without mode capture, or one that restarts while busy, changes the outcome. Aborts in mid-sequence and after completion check that every control drops at once and that a later start still completes.

// File: rtl/spi_bup_pkg.sv
package spi_bup_pkg;

  localparam int CTL_GEN  = 0;
  localparam int CTL_PATH = 1;
  localparam int CTL_FS   = 2;
  localparam int NUM_CTL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD_PATH,
    ST_HOLD_GEN,
    ST_WAIT_GEN,
    ST_GATE,
    ST_WAIT_PATH,
    ST_FSYNC,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic master;
    logic dma;
  } seq_mode_t;

endpackage

// File: rtl/spi_bup_tick_cnt.sv
module spi_bup_tick_cnt #(
  parameter int WAIT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);

  localparam int CW = (WAIT_TICKS < 2) ? 1 : $clog2(WAIT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_bup_rel_bank.sv
module spi_bup_rel_bank #(
  parameter int N_CTL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CTL-1:0] set_i,
  input  logic [N_CTL-1:0] clr_i,
  output logic [N_CTL-1:0] run_o
);

  for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)        run_o[i] <= 1'b0;
      else if (clr_i[i]) run_o[i] <= 1'b0;
      else if (set_i[i]) run_o[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_bup_fsm.sv
module spi_bup_fsm
  import spi_bup_pkg::*;
#(
  parameter int WAIT_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               master_i,
  input  logic               dma_mode_i,
  input  logic               dma_ready_i,
  input  logic               tx_loaded_i,
  input  logic               gen_tick_i,
  output logic [NUM_CTL-1:0] set_o,
  output logic [NUM_CTL-1:0] clr_o,
  output logic               busy_o,
  output logic               done_o,
  output seq_mode_t          mode_o
);

  seq_state_t st_q, st_d;
  seq_mode_t  mode_q;
  logic       cnt_en, cnt_clr, expired;

  spi_bup_tick_cnt #(.WAIT_TICKS(WAIT_TICKS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cnt_clr),
    .en_i     (cnt_en),
    .expired_o(expired)
  );

  always_comb begin
    st_d    = st_q;
    set_o   = '0;
    clr_o   = '0;
    cnt_en  = 1'b0;
    cnt_clr = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          clr_o[CTL_PATH] = 1'b1;
          clr_o[CTL_FS]   = 1'b1;
          st_d            = ST_HOLD_PATH;
        end
      end
      ST_HOLD_PATH: begin
        clr_o[CTL_GEN] = 1'b1;
        st_d           = ST_HOLD_GEN;
      end
      ST_HOLD_GEN: begin
        set_o[CTL_GEN] = 1'b1;
        st_d           = ST_WAIT_GEN;
      end
      ST_WAIT_GEN: begin
        cnt_clr = 1'b0;
        cnt_en  = gen_tick_i;
        if (expired) st_d = ST_GATE;
      end
      ST_GATE: begin
        if (!mode_q.dma || dma_ready_i) begin
          set_o[CTL_PATH] = 1'b1;
          st_d            = ST_WAIT_PATH;
        end
      end
      ST_WAIT_PATH: begin
        cnt_clr = 1'b0;
        cnt_en  = gen_tick_i;
        if (expired) st_d = mode_q.master ? ST_FSYNC : ST_DONE;
      end
      ST_FSYNC: begin
        if (tx_loaded_i) begin
          set_o[CTL_FS] = 1'b1;
          st_d          = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (abort_i) begin
      st_d    = ST_IDLE;
      set_o   = '0;
      clr_o   = '1;
      cnt_en  = 1'b0;
      cnt_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i && !abort_i) begin
        mode_q.master <= master_i;
        mode_q.dma    <= dma_mode_i;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);
  assign mode_o = mode_q;

endmodule

// File: rtl/spi_bringup_seq.sv
module spi_bringup_seq
  import spi_bup_pkg::*;
#(
  parameter int WAIT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic master_i,
  input  logic dma_mode_i,
  input  logic dma_ready_i,
  input  logic tx_loaded_i,
  input  logic gen_tick_i,
  output logic gen_run_o,
  output logic path_run_o,
  output logic fsync_run_o,
  output logic busy_o,
  output logic done_o
);

  logic [NUM_CTL-1:0] ctl_set, ctl_clr, ctl_run;
  seq_mode_t          mode;
  logic               lat_master, lat_dma;

  spi_bup_fsm #(.WAIT_TICKS(WAIT_TICKS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .master_i   (master_i),
    .dma_mode_i (dma_mode_i),
    .dma_ready_i(dma_ready_i),
    .tx_loaded_i(tx_loaded_i),
    .gen_tick_i (gen_tick_i),
    .set_o      (ctl_set),
    .clr_o      (ctl_clr),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mode_o     (mode)
  );

  spi_bup_rel_bank #(.N_CTL(NUM_CTL)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(ctl_set),
    .clr_i(ctl_clr),
    .run_o(ctl_run)
  );

  assign gen_run_o   = ctl_run[CTL_GEN];
  assign path_run_o  = ctl_run[CTL_PATH];
  assign fsync_run_o = ctl_run[CTL_FS];
  assign lat_master  = mode.master;
  assign lat_dma     = mode.dma;

endmodule

// File: rtl/spi_bup_chk.sv
module spi_bup_chk (
  input logic clk,
  input logic rst_n,
  input logic abort_i,
  input logic dma_ready_i,
  input logic tx_loaded_i,
  input logic gen_run_o,
  input logic path_run_o,
  input logic fsync_run_o,
  input logic busy_o,
  input logic done_o,
  input logic lat_master,
  input logic lat_dma
);

  // R3
  gen_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_run_o) |-> !path_run_o && !fsync_run_o);

  // R3
  path_after_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_run_o) |-> gen_run_o);

  // R5
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(path_run_o) && lat_dma) |-> $past(dma_ready_i));

  // R7
  fsync_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_run_o) |-> lat_master && $past(tx_loaded_i) && path_run_o);

  // R8
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gen_run_o, path_run_o, fsync_run_o})
      <= $countones($past({gen_run_o, path_run_o, fsync_run_o})) + 1);

  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !gen_run_o && !path_run_o && !fsync_run_o && !busy_o && !done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o ##1 (!done_o && !busy_o));

endmodule

bind spi_bringup_seq spi_bup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort_i    (abort_i),
  .dma_ready_i(dma_ready_i),
  .tx_loaded_i(tx_loaded_i),
  .gen_run_o  (gen_run_o),
  .path_run_o (path_run_o),
  .fsync_run_o(fsync_run_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .lat_master (lat_master),
  .lat_dma    (lat_dma)
);

// File: tb/tb_spi_bringup_seq.sv
module tb_spi_bringup_seq;

  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n, start_i, abort_i, master_i, dma_mode_i, dma_ready_i, tx_loaded_i, gen_tick_i;
  logic gen_run_o, path_run_o, fsync_run_o, busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_bringup_seq #(.WAIT_TICKS(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .master_i(master_i), .dma_mode_i(dma_mode_i), .dma_ready_i(dma_ready_i),
    .tx_loaded_i(tx_loaded_i), .gen_tick_i(gen_tick_i),
    .gen_run_o(gen_run_o), .path_run_o(path_run_o), .fsync_run_o(fsync_run_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit m, input bit d, input int per, input int rdy_at, input int ld_at);
    int  cnt = 0, cnt2 = 0, gen_rises = 0, dones = 0, busy_bad = 0, fall_bad = 0;
    bit  og, op, of, done_seen = 0, p_tick = 0, p_rdy = 0, p_ld = 0;
    @(negedge clk);
    master_i = m; dma_mode_i = d; start_i = 1'b1;
    gen_tick_i = 1'b0; dma_ready_i = 1'b0; tx_loaded_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; master_i = ~m; dma_mode_i = ~d;  // R11: later changes ignored
    check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    check(!path_run_o && !fsync_run_o, "R2 paths held", {path_run_o, fsync_run_o}, 0);
    og = gen_run_o; op = path_run_o; of = fsync_run_o;
    for (int c = 0; c < 500; c++) begin
      gen_tick_i  = (c % per == 0);
      dma_ready_i = (c >= rdy_at);
      tx_loaded_i = (c >= ld_at);
      start_i     = (c == 3);          // R2: stray start while busy
      p_tick = gen_tick_i; p_rdy = dma_ready_i; p_ld = tx_loaded_i;
      @(negedge clk);
      start_i = 1'b0;
      if (done_seen) begin
        check(!busy_o && !done_o, "R10 idle after done", {busy_o, done_o}, 0);
        break;
      end
      if ((op && !path_run_o) || (of && !fsync_run_o) || (og && !gen_run_o && gen_rises > 0))
        fall_bad++;
      if (int'(gen_run_o && !og) + int'(path_run_o && !op) + int'(fsync_run_o && !of) > 1)
        fall_bad++;
      if (gen_run_o && !og) begin
        gen_rises++;
        check(!path_run_o && !fsync_run_o, "R3 gen first", {path_run_o, fsync_run_o}, 0);
        cnt = 0;
      end
      if (path_run_o && !op) begin
        check(og, "R3 path after gen", og, 1);
        if (!d) check(cnt == N, "R4 ticks before path", cnt, N);
        else begin
          check(cnt >= N, "R4 ticks before path (dma)", cnt, N);
          check(p_rdy, "R5 dma ready at path release", p_rdy, 1);
        end
        cnt2 = 0;
      end else if (og && !op) begin
        cnt += int'(p_tick);
      end
      if (fsync_run_o && !of) begin
        check(m, "R7 fsync only in master", 0, 1);
        check(p_ld, "R7 fsync needs tx loaded", p_ld, 1);
        check(cnt2 >= N, "R6 ticks before fsync", cnt2, N);
      end else if (op && !of) begin
        cnt2 += int'(p_tick);
      end
      if (done_o) begin
        dones++;
        done_seen = 1;
        if (!m) check(cnt2 == N, "R6 slave done after ticks", cnt2, N);
        check(busy_o, "R10 busy during done", busy_o, 1);
        check(gen_run_o && path_run_o && (fsync_run_o == m), "R11 final controls",
              {gen_run_o, path_run_o, fsync_run_o}, {2'b11, m});
      end else if (!busy_o) begin
        busy_bad++;
      end
      og = gen_run_o; op = path_run_o; of = fsync_run_o;
    end
    check(dones == 1, "R10 one done pulse", dones, 1);
    check(gen_rises == 1, "R2 start ignored while busy", gen_rises, 1);
    check(busy_bad == 0, "R10 busy held", busy_bad, 0);
    check(fall_bad == 0, "R8 single-step releases", fall_bad, 0);
  endtask

  task automatic abort_when_path(input bit after_done);
    @(negedge clk);
    master_i = 1'b1; dma_mode_i = 1'b0; start_i = 1'b1;
    gen_tick_i = 1'b1; tx_loaded_i = 1'b1; dma_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (after_done ? (!busy_o && fsync_run_o) : path_run_o) break;
      @(negedge clk);
    end
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check(!gen_run_o && !path_run_o && !fsync_run_o && !busy_o && !done_o, "R9 abort drops all",
          {gen_run_o, path_run_o, fsync_run_o, busy_o, done_o}, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; master_i = 1'b0; dma_mode_i = 1'b0;
    dma_ready_i = 1'b0; tx_loaded_i = 1'b0; gen_tick_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!gen_run_o && !path_run_o && !fsync_run_o && !busy_o && !done_o, "R1 reset state",
          {gen_run_o, path_run_o, fsync_run_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int per = 1; per <= 3; per++)
          for (int r = 0; r < 2; r++)
            for (int l = 0; l < 2; l++)
              run_seq(m[0], d[0], per, r * 30, l * 40);
    abort_when_path(1'b0);
    run_seq(1'b0, 1'b1, 2, 10, 0);   // R9 recovery after abort
    abort_when_path(1'b1);
    run_seq(1'b1, 1'b1, 3, 5, 25);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule